// File: doc/BRIEF.md
# Thermal Auto-Sampling Alarm Controller

The controller polls a set of temperature-sensor channels on its own while auto mode is on. A sweep requests one code per channel from an external converter through a request/valid handshake. The controller masks each code to the data width and can invert it against a fixed reference. It stores the result per channel and compares it against that channel's threshold. The direction of the comparison comes from a configuration pin, so converters whose code rises with temperature and converters whose code falls with it are both supported.

A channel that reads hot for enough consecutive samples raises a pending interrupt. A separately debounced shutdown flag drives a GPIO-bound shutdown pin or a reset-unit shutdown pin, according to per-channel routing. Both shutdown pins follow a programmable polarity. While any channel reads hot, sweeps repeat at a faster interval. Intervals are counted in ticks of a millisecond strobe, which a prescaler derives from the clock.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset `adc_req_o` and `irq_o` are low and both shutdown pins are high (polarity 0, inactive). The registers read their defaults: control 0, routing 0, pending 0, slow period 250, fast period 50, both debounce counts 4.
- R2: Register map, byte offsets:
  - 0x00 control: bit0 auto enable, bit1 q-select, bit 4+n compare enable for channel n, bit8 shutdown polarity.
  - 0x04 routing: bit n interrupt enable, bit 4+n shutdown to GPIO, bit 8+n shutdown to reset unit.
  - 0x08 pending: bit n.
  - 0x10 slow period and 0x14 fast period, both in ticks.
  - 0x18 interrupt debounce and 0x1C shutdown debounce.
  - 0x20+4n data, read-only.
  - 0x40+4n threshold.

  Writable fields read back what was written, truncated to field width.
- R3: While auto enable is set, each sweep raises `adc_req_o` for channels 0..N-1 in order. The request and `adc_ch_o` are held until `adc_valid_i`. Clearing auto enable drops the request on the next cycle and starts no sweep.
- R4: The stored data is the low DATA_W bits of `adc_code_i`. Writes to a data offset have no effect.
- R5: With q-select set, the stored data is (1024 − masked code) modulo 2^DATA_W.
- R6: A sample is hot when its channel's compare enable is set and the stored data is above the threshold (`inc_mode_i`=1) or below it (`inc_mode_i`=0).
- R7: A per-channel interrupt counter counts consecutive hot samples and restarts on any non-hot sample. When a hot sample brings the count to at least the interrupt debounce value, pending bit n is set, provided interrupt enable n is set. This repeats on every further hot sample.
- R8: Writing 1 to a pending bit clears it. `irq_o` is the OR of the pending bits.
- R9: A separate counter with the shutdown debounce value sets a sticky per-channel shutdown flag, which only reset clears. The GPIO pin is active when any flagged channel has GPIO routing; the reset-unit pin is active when any flagged channel has reset routing.
- R10: Shutdown pins are active-high when polarity is 1 and active-low when it is 0.
- R11: The next sweep starts the slow period after the previous sweep ends. The fast period is used instead while any channel's last sample was hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inc_mode_i | input | 1 | 1: higher code is hotter; 0: lower code is hotter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on the offset |
| adc_req_o | output | 1 | Sample request |
| adc_ch_o | output | 1 | Channel being requested |
| adc_valid_i | input | 1 | Code valid, completes the request |
| adc_code_i | input | 12 | Raw converter code |
| irq_o | output | 1 | Interrupt, OR of pending bits |
| shut_gpio_o | output | 1 | Shutdown pin toward GPIO |
| shut_rst_o | output | 1 | Shutdown pin toward the reset unit |

## Verification
A debounce counter that fails to restart shows as a pending bit or shutdown pin set one or more sweeps early, after a cool sample broke the streak. A counter stuck too low shows as the event arriving sweeps late. A wrong hot flag shows up one full period later, in the spacing between sweep completions on the handshake. A broken sequencer shows within a cycle, as a request that drops or changes channel without a valid. Sweep counts are therefore chosen right at the debounce boundaries.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_ROUTE  = 'h04;
  localparam int OFF_PEND   = 'h08;
  localparam int OFF_PSLOW  = 'h10;
  localparam int OFF_PFAST  = 'h14;
  localparam int OFF_DBINT  = 'h18;
  localparam int OFF_DBSHUT = 'h1C;
  localparam int OFF_DATA   = 'h20;
  localparam int OFF_THR    = 'h40;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_e;
endpackage

// File: rtl/thermal_tick.sv
module thermal_tick #(
  parameter int TICK_DIV = 100000,
  parameter int PER_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             due_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] elapsed_q;
  logic             tick;

  assign tick  = (pre_q == PRE_W'(TICK_DIV - 1));
  assign due_o = run_i && (elapsed_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      elapsed_q <= '0;
    end else begin
      if (!run_i || tick) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
      if (!run_i || restart_i)   elapsed_q <= '0;
      else if (tick && !due_o)   elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/thermal_chan.sv
module thermal_chan #(
  parameter int DATA_W = 12,
  parameter int DEB_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              inc_mode_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic [DEB_W-1:0]  deb_int_i,
  input  logic [DEB_W-1:0]  deb_shut_i,
  output logic              hot_o,
  output logic              int_evt_o,
  output logic              shut_evt_o
);
  logic             hot_now;
  logic [DEB_W-1:0] int_cnt_q, shut_cnt_q, int_nxt, shut_nxt;

  assign hot_now  = cmp_en_i && (inc_mode_i ? (code_i > thr_i) : (code_i < thr_i));
  assign int_nxt  = (&int_cnt_q)  ? int_cnt_q  : int_cnt_q + 1'b1;
  assign shut_nxt = (&shut_cnt_q) ? shut_cnt_q : shut_cnt_q + 1'b1;

  assign int_evt_o  = sample_i && hot_now && (int_nxt >= deb_int_i);
  assign shut_evt_o = sample_i && hot_now && (shut_nxt >= deb_shut_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_cnt_q  <= '0;
      shut_cnt_q <= '0;
      hot_o      <= 1'b0;
    end else if (sample_i) begin
      hot_o <= hot_now;
      if (hot_now) begin
        int_cnt_q  <= int_nxt;
        shut_cnt_q <= shut_nxt;
      end else begin
        int_cnt_q  <= '0;
        shut_cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADC_W    = 12,
  parameter int DATA_W   = 12,
  parameter int PER_W    = 16,
  parameter int DEB_W    = 8,
  parameter int AW       = 8,
  parameter int TICK_DIV = 100000,
  parameter int Q_REF    = 1024,
  parameter int SLOW_DEF = 250,
  parameter int FAST_DEF = 50,
  parameter int DEB_DEF  = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RW      = PER_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_mode_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  output logic [RW-1:0]     reg_rdata_o,
  output logic              adc_req_o,
  output logic [CH_W-1:0]   adc_ch_o,
  input  logic              adc_valid_i,
  input  logic [ADC_W-1:0]  adc_code_i,
  output logic              irq_o,
  output logic              shut_gpio_o,
  output logic              shut_rst_o
);
  logic              auto_en, q_sel, pol;
  logic [NUM_CH-1:0] cmp_en, int_en, gpio_en, rst_en, pending, shut_lat;
  logic [NUM_CH-1:0] hot, int_evt, shut_evt, sample;
  logic [PER_W-1:0]  per_slow, per_fast;
  logic [DEB_W-1:0]  deb_int, deb_shut;
  logic [DATA_W-1:0] data_q [NUM_CH];
  logic [DATA_W-1:0] thr_q  [NUM_CH];
  logic [DATA_W-1:0] code_m, code_p;
  seq_e              state_q;
  logic [CH_W-1:0]   ch_q;
  logic              take, last, sweep_done, due;

  // register write decode
  logic wr_ctrl, wr_route, wr_pend, wr_pslow, wr_pfast, wr_dbint, wr_dbshut;
  assign wr_ctrl   = reg_we_i && (reg_addr_i == AW'(OFF_CTRL));
  assign wr_route  = reg_we_i && (reg_addr_i == AW'(OFF_ROUTE));
  assign wr_pend   = reg_we_i && (reg_addr_i == AW'(OFF_PEND));
  assign wr_pslow  = reg_we_i && (reg_addr_i == AW'(OFF_PSLOW));
  assign wr_pfast  = reg_we_i && (reg_addr_i == AW'(OFF_PFAST));
  assign wr_dbint  = reg_we_i && (reg_addr_i == AW'(OFF_DBINT));
  assign wr_dbshut = reg_we_i && (reg_addr_i == AW'(OFF_DBSHUT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_en  <= 1'b0;
      q_sel    <= 1'b0;
      pol      <= 1'b0;
      cmp_en   <= '0;
      int_en   <= '0;
      gpio_en  <= '0;
      rst_en   <= '0;
      per_slow <= PER_W'(SLOW_DEF);
      per_fast <= PER_W'(FAST_DEF);
      deb_int  <= DEB_W'(DEB_DEF);
      deb_shut <= DEB_W'(DEB_DEF);
    end else begin
      if (wr_ctrl) begin
        auto_en <= reg_wdata_i[0];
        q_sel   <= reg_wdata_i[1];
        cmp_en  <= reg_wdata_i[4 +: NUM_CH];
        pol     <= reg_wdata_i[8];
      end
      if (wr_route) begin
        int_en  <= reg_wdata_i[0 +: NUM_CH];
        gpio_en <= reg_wdata_i[4 +: NUM_CH];
        rst_en  <= reg_wdata_i[8 +: NUM_CH];
      end
      if (wr_pslow)  per_slow <= reg_wdata_i[PER_W-1:0];
      if (wr_pfast)  per_fast <= reg_wdata_i[PER_W-1:0];
      if (wr_dbint)  deb_int  <= reg_wdata_i[DEB_W-1:0];
      if (wr_dbshut) deb_shut <= reg_wdata_i[DEB_W-1:0];
    end
  end

  // sample sequencer
  assign take       = (state_q == SEQ_BUSY) && adc_valid_i;
  assign last       = (ch_q == CH_W'(NUM_CH - 1));
  assign sweep_done = take && last;
  assign adc_req_o  = (state_q == SEQ_BUSY);
  assign adc_ch_o   = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
    end else if (!auto_en) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (due) begin
        state_q <= SEQ_BUSY;
        ch_q    <= '0;
      end
    end else if (take) begin
      if (last) state_q <= SEQ_IDLE;
      else      ch_q    <= ch_q + 1'b1;
    end
  end

  thermal_tick #(.TICK_DIV(TICK_DIV), .PER_W(PER_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (auto_en),
    .restart_i (sweep_done),
    .period_i  ((|hot) ? per_fast : per_slow),
    .due_o     (due)
  );

  assign code_m = adc_code_i[DATA_W-1:0];
  assign code_p = q_sel ? (DATA_W'(Q_REF) - code_m) : code_m;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign sample[n] = take && (ch_q == CH_W'(n));
    thermal_chan #(.DATA_W(DATA_W), .DEB_W(DEB_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sample_i   (sample[n]),
      .inc_mode_i (inc_mode_i),
      .cmp_en_i   (cmp_en[n]),
      .code_i     (code_p),
      .thr_i      (thr_q[n]),
      .deb_int_i  (deb_int),
      .deb_shut_i (deb_shut),
      .hot_o      (hot[n]),
      .int_evt_o  (int_evt[n]),
      .shut_evt_o (shut_evt[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending  <= '0;
      shut_lat <= '0;
      for (int n = 0; n < NUM_CH; n++) begin
        data_q[n] <= '0;
        thr_q[n]  <= '0;
      end
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (int_evt[n] && int_en[n])       pending[n] <= 1'b1;
        else if (wr_pend && reg_wdata_i[n]) pending[n] <= 1'b0;
        if (shut_evt[n]) shut_lat[n] <= 1'b1;
        if (sample[n])   data_q[n]   <= code_p;
        if (reg_we_i && (reg_addr_i == AW'(OFF_THR + 4 * n)))
          thr_q[n] <= reg_wdata_i[DATA_W-1:0];
      end
    end
  end

  assign irq_o       = |pending;
  assign shut_gpio_o = pol ? (|(shut_lat & gpio_en)) : ~(|(shut_lat & gpio_en));
  assign shut_rst_o  = pol ? (|(shut_lat & rst_en))  : ~(|(shut_lat & rst_en));

  // register read
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(OFF_CTRL): begin
        reg_rdata_o[0]            = auto_en;
        reg_rdata_o[1]            = q_sel;
        reg_rdata_o[4 +: NUM_CH]  = cmp_en;
        reg_rdata_o[8]            = pol;
      end
      AW'(OFF_ROUTE): begin
        reg_rdata_o[0 +: NUM_CH]  = int_en;
        reg_rdata_o[4 +: NUM_CH]  = gpio_en;
        reg_rdata_o[8 +: NUM_CH]  = rst_en;
      end
      AW'(OFF_PEND):   reg_rdata_o[NUM_CH-1:0] = pending;
      AW'(OFF_PSLOW):  reg_rdata_o[PER_W-1:0]  = per_slow;
      AW'(OFF_PFAST):  reg_rdata_o[PER_W-1:0]  = per_fast;
      AW'(OFF_DBINT):  reg_rdata_o[DEB_W-1:0]  = deb_int;
      AW'(OFF_DBSHUT): reg_rdata_o[DEB_W-1:0]  = deb_shut;
      default: begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (reg_addr_i == AW'(OFF_DATA + 4 * n)) reg_rdata_o[DATA_W-1:0] = data_q[n];
          if (reg_addr_i == AW'(OFF_THR + 4 * n))  reg_rdata_o[DATA_W-1:0] = thr_q[n];
        end
      end
    endcase
  end
endmodule

// File: rtl/thermal_alarm_checker.sv
module thermal_alarm_checker #(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              auto_en,
  input logic              adc_req,
  input logic              adc_valid,
  input logic [CH_W-1:0]   adc_ch,
  input logic              irq,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] int_en,
  input logic [NUM_CH-1:0] shut_lat
);
  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_req && !adc_valid && auto_en) |=> (adc_req && $stable(adc_ch)));

  assert_no_req_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en |=> !adc_req);

  assert_irq_after_sample_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq) |-> $past(adc_req && adc_valid));

  assert_pend_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending & ~$past(pending) & ~$past(int_en)) == '0));

  assert_shut_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(shut_lat) & ~shut_lat) == '0));
endmodule

bind thermal_alarm_ctrl thermal_alarm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .auto_en   (auto_en),
  .adc_req   (adc_req_o),
  .adc_valid (adc_valid_i),
  .adc_ch    (adc_ch_o),
  .irq       (irq_o),
  .pending   (pending),
  .int_en    (int_en),
  .shut_lat  (shut_lat)
);

// File: tb/thermal_alarm_ctrl_test.sv
module thermal_alarm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_mode = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        adc_req, adc_valid = 1'b0;
  logic        adc_ch;
  logic [11:0] adc_code = '0;
  logic        irq, shut_gpio, shut_rst;
  logic [11:0] codes [2];

  int vectors = 0, fails = 0;
  int cyc = 0, sweeps = 0, last_t = 0, prev_t = 0;

  thermal_alarm_ctrl #(.TICK_DIV(10), .DATA_W(10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .inc_mode_i(inc_mode),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .adc_req_o(adc_req), .adc_ch_o(adc_ch), .adc_valid_i(adc_valid), .adc_code_i(adc_code),
    .irq_o(irq), .shut_gpio_o(shut_gpio), .shut_rst_o(shut_rst)
  );

  always #5 clk = ~clk;

  // converter model: answers a held request every other cycle
  always @(negedge clk) begin
    if (!rst_n) adc_valid = 1'b0;
    else if (adc_req && !adc_valid) begin
      adc_valid = 1'b1;
      adc_code  = codes[adc_ch];
    end else adc_valid = 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && adc_req && adc_valid && adc_ch == 1'b1) begin
      sweeps <= sweeps + 1;
      prev_t <= last_t;
      last_t <= cyc;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; inc_mode = 1'b1;
    codes[0] = '0; codes[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_sweeps(int k);
    int target = sweeps + k;
    while (sweeps < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fast_setup();
    wr('h10, 16'd8);
    wr('h14, 16'd2);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    check("R1 req", adc_req, 0);
    check("R1 irq", irq, 0);
    check("R1 gpio", shut_gpio, 1);
    check("R1 rst", shut_rst, 1);
    rd('h00, d); check("R1 ctrl", d, 0);
    rd('h04, d); check("R1 route", d, 0);
    rd('h08, d); check("R1 pend", d, 0);
    rd('h10, d); check("R1 slow", d, 250);
    rd('h14, d); check("R1 fast", d, 50);
    rd('h18, d); check("R1 dbint", d, 4);
    rd('h1C, d); check("R1 dbshut", d, 4);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    do_reset();
    wr('h00, 16'h0132); rd('h00, d); check("R2 ctrl", d, 16'h0132);
    wr('h04, 16'h0321); rd('h04, d); check("R2 route", d, 16'h0321);
    wr('h44, 16'hFABC); rd('h44, d); check("R2 thr1 trunc", d, 16'h02BC);
    wr('h20, 16'h0177); rd('h20, d); check("R4 data ro", d, 0);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    int s0;
    do_reset(); fast_setup();
    codes[0] = 12'hDA3; codes[1] = 12'h123;
    wr('h00, 16'h0001);
    wait_sweeps(1);
    rd('h20, d); check("R4 data0 mask", d, 16'h01A3);
    rd('h24, d); check("R4 data1", d, 16'h0123);
    wr('h00, 16'h0000);
    s0 = sweeps;
    repeat (300) @(negedge clk);
    check("R3 no sweep when off", sweeps, s0);
    check("R3 req low when off", adc_req, 0);
  endtask

  task automatic t_qsel();
    logic [15:0] d;
    do_reset(); fast_setup();
    codes[0] = 12'h100; codes[1] = 12'h3FF;
    wr('h00, 16'h0003);
    wait_sweeps(1);
    rd('h20, d); check("R5 qsel ch0", d, 16'h0300);
    rd('h24, d); check("R5 qsel ch1", d, 16'h0001);
  endtask

  task automatic int_setup(logic [15:0] route);
    do_reset(); fast_setup();
    wr('h18, 16'd3);
    wr('h40, 16'd500);
    wr('h04, route);
    codes[0] = 12'd600; codes[1] = 12'd0;
  endtask

  task automatic t_int_debounce();
    logic [15:0] d;
    int_setup(16'h0001);
    wr('h00, 16'h0011);
    wait_sweeps(1); rd('h08, d); check("R7 after 1 hot", d, 0);
    wait_sweeps(1); rd('h08, d); check("R7 after 2 hot", d, 0);
    wait_sweeps(1); rd('h08, d); check("R7 after 3 hot", d, 1);
    check("R8 irq set", irq, 1);
    wr('h08, 16'h0001); rd('h08, d); check("R8 w1c", d, 0);
    check("R8 irq clear", irq, 0);
    wait_sweeps(1); rd('h08, d); check("R7 re-raise", d, 1);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    int_setup(16'h0001);
    wr('h00, 16'h0011);
    wait_sweeps(2);
    codes[0] = 12'd400; wait_sweeps(1);
    codes[0] = 12'd600; wait_sweeps(2);
    rd('h08, d); check("R7 streak restarted", d, 0);
    wait_sweeps(1); rd('h08, d); check("R7 after restart 3 hot", d, 1);
  endtask

  task automatic t_int_masked();
    logic [15:0] d;
    int_setup(16'h0000);
    wr('h00, 16'h0011);
    wait_sweeps(4);
    rd('h08, d); check("R7 int disabled", d, 0);
    check("R8 irq stays low", irq, 0);
    int_setup(16'h0001);
    wr('h00, 16'h0001);
    wait_sweeps(4);
    rd('h08, d); check("R6 compare disabled", d, 0);
  endtask

  task automatic t_decrement();
    logic [15:0] d;
    int_setup(16'h0001);
    inc_mode = 1'b0;
    wr('h18, 16'd1);
    wr('h40, 16'd700);
    codes[0] = 12'd800;
    wr('h00, 16'h0011);
    wait_sweeps(2); rd('h08, d); check("R6 dec cool", d, 0);
    codes[0] = 12'd600;
    wait_sweeps(1); rd('h08, d); check("R6 dec hot", d, 1);
  endtask

  task automatic t_period();
    int iv;
    int_setup(16'h0000);
    wr('h18, 16'd200);
    codes[0] = 12'd100;
    wr('h00, 16'h0011);
    wait_sweeps(3);
    iv = last_t - prev_t;
    check("R11 slow interval", (iv >= 70 && iv <= 90), 1);
    codes[0] = 12'd600;
    wait_sweeps(3);
    iv = last_t - prev_t;
    check("R11 fast interval", (iv >= 10 && iv <= 30), 1);
  endtask

  task automatic t_shutdown();
    do_reset(); fast_setup();
    wr('h1C, 16'd2);
    wr('h44, 16'd500);
    wr('h04, 16'h0200);
    codes[1] = 12'd600;
    wr('h00, 16'h0121);
    check("R10 idle high pol", shut_rst, 0);
    wait_sweeps(1);
    check("R9 rst after 1", shut_rst, 0);
    wait_sweeps(1);
    check("R9 rst after 2", shut_rst, 1);
    check("R9 gpio unrouted", shut_gpio, 0);
    check("R9 no irq", irq, 0);
    codes[1] = 12'd100;
    wait_sweeps(1);
    check("R9 sticky", shut_rst, 1);
    wr('h00, 16'h0021);
    check("R10 low pol active", shut_rst, 0);
    check("R10 low pol inactive gpio", shut_gpio, 1);
  endtask

  task automatic t_gpio();
    do_reset(); fast_setup();
    wr('h1C, 16'd1);
    wr('h40, 16'd500);
    wr('h04, 16'h0010);
    codes[0] = 12'd600;
    wr('h00, 16'h0011);
    wait_sweeps(1);
    check("R9 gpio active low", shut_gpio, 0);
    check("R9 rst unrouted", shut_rst, 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_capture();
    t_qsel();
    t_int_debounce();
    t_restart();
    t_int_masked();
    t_decrement();
    t_period();
    t_shutdown();
    t_gpio();
    summary();
    $finish;
  end
endmodule